// File: doc/BRIEF.md
# Three-Phase Gate Command Shoot-Through Guard

This block sits between a motor controller's PWM outputs and the gate drivers of a three-phase inverter bridge. Each phase has an upper and a lower gate command. Both are active-low: a low level asks for that switch to conduct. The block synchronises every command into its clock domain and passes it through as an active-high gate enable. If the upper and lower commands of one phase are asserted together, that phase's leg would short the DC link. In that case the block switches off both enables of that phase and pulls the shared active-low fault flag low.

The fault is latched separately for each phase. It does not clear when the conflicting commands go away. A phase is released only by a fresh high-to-low transition on the command that completed the conflict, which is the one of the pair that went low later. While a phase is latched, the other phases keep following their commands. The braking-chopper command is synchronised and delayed like the others but is never part of any conflict check. All pins are plain level signals with no handshake. At a 100 MHz clock, a command change reaches the outputs after three clock edges (30 ns), which is well within the 100 ns detection budget.

Top module: `leg_interlock`

## Requirements
- R1: After reset, all gate enables and the brake enable are 0 and `fault_n` is 1.
- R2: In an unlatched phase, `gate_hi[i]` equals the inverse of `cmd_hi_n[i]` and `gate_lo[i]` equals the inverse of `cmd_lo_n[i]`. A command change appears on the output at the third rising clock edge after it is applied and not at the second.
- R3: When `cmd_hi_n[i]` and `cmd_lo_n[i]` are both 0, that phase trips: both enables of the phase become 0 and `fault_n` becomes 0, three edges after the overlap begins. The two enables of a phase are never 1 together.
- R4: A tripped phase stays tripped with both enables at 0 when its commands return high or when only one command is low. `fault_n` stays 0.
- R5: A tripped phase is released by a high-to-low edge on its "late" command, provided the other command of the pair is high at that moment. From that edge on, the phase follows its commands again.
- R6: A high-to-low edge on the "early" command of a tripped phase, meaning the one that went low first, does not release it.
- R7: When both commands of a phase go low on the same synchronised edge, the lower command counts as the late one.
- R8: A high-to-low edge on the late command while the other command is still low trips the phase again, and it stays latched.
- R9: A trip in one phase does not affect the enables of the other phases.
- R10: `fault_n` is 0 while any phase is tripped and returns to 1 only when every phase has been released.
- R11: `brake_en` equals the inverse of `cmd_brake_n` with the same three-edge delay, and it is never blocked by any phase trip.

Top module ports appear below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi_n | input | 3 | Upper-switch commands, active-low, bit i = phase i |
| cmd_lo_n | input | 3 | Lower-switch commands, active-low, bit i = phase i |
| cmd_brake_n | input | 1 | Brake chopper command, active-low |
| gate_hi | output | 3 | Upper gate enables, active-high |
| gate_lo | output | 3 | Lower gate enables, active-high |
| brake_en | output | 1 | Brake gate enable, active-high |
| fault_n | output | 1 | Shoot-through fault, active-low, latched |

## Verification
Every result of this block is due at the third rising edge after a command change. Two edges are spent in the synchroniser and one in the output or latch register. The bench therefore drives commands on a falling clock edge, waits three rising edges and samples on the next falling edge. The latency check samples after only two edges and expects the previous value. Trip, hold and release checks reuse the same three-edge settle after each command step. This keeps the early or late ordering of the conflicting commands one full settle apart, except in the simultaneous case.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // Which command of a pair completed the overlap and so owns the release.
  typedef enum logic {
    LATE_HI = 1'b0,
    LATE_LO = 1'b1
  } late_sel_e;
endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/ilk_phase.sv
module ilk_phase
  import ilk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hi_s_n,
  input  logic lo_s_n,
  output logic gate_hi,
  output logic gate_lo,
  output logic tripped
);
  logic      hi_prev, lo_prev;
  late_sel_e late_q;
  logic      both_on, hi_fall, lo_fall, late_fall, trip_nxt;

  always_comb begin
    both_on   = !hi_s_n && !lo_s_n;
    hi_fall   = hi_prev && !hi_s_n;
    lo_fall   = lo_prev && !lo_s_n;
    late_fall = (late_q == LATE_LO) ? lo_fall : hi_fall;
    trip_nxt  = both_on || (tripped && !late_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_prev <= 1'b1;
      lo_prev <= 1'b1;
      late_q  <= LATE_LO;
      tripped <= 1'b0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      hi_prev <= hi_s_n;
      lo_prev <= lo_s_n;
      tripped <= trip_nxt;
      gate_hi <= !hi_s_n && !trip_nxt;
      gate_lo <= !lo_s_n && !trip_nxt;
      if (both_on && !tripped)
        late_q <= lo_fall ? LATE_LO : LATE_HI;
    end
  end

  AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_s_n && !lo_s_n) |=> (tripped && !gate_hi && !gate_lo)); // R3
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !late_fall) |=> tripped); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && late_fall && !both_on) |=> !tripped); // R5
  AST_LATCHED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> (!gate_hi && !gate_lo)); // R4
endmodule

// File: rtl/leg_interlock.sv
module leg_interlock #(
  parameter int NUM_PH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] cmd_hi_n,
  input  logic [NUM_PH-1:0] cmd_lo_n,
  input  logic              cmd_brake_n,
  output logic [NUM_PH-1:0] gate_hi,
  output logic [NUM_PH-1:0] gate_lo,
  output logic              brake_en,
  output logic              fault_n
);
  localparam int NCMD = 2 * NUM_PH + 1;

  logic [NCMD-1:0]   raw_cmd, sync_cmd;
  logic [NUM_PH-1:0] hi_s_n, lo_s_n, tripped;

  assign raw_cmd = {cmd_brake_n, cmd_lo_n, cmd_hi_n};

  ilk_sync #(.WIDTH(NCMD), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_cmd),
    .d_out (sync_cmd)
  );

  assign hi_s_n = sync_cmd[NUM_PH-1:0];
  assign lo_s_n = sync_cmd[2*NUM_PH-1:NUM_PH];

  genvar p;
  generate
    for (p = 0; p < NUM_PH; p++) begin : g_ph
      ilk_phase u_ph (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_s_n  (hi_s_n[p]),
        .lo_s_n  (lo_s_n[p]),
        .gate_hi (gate_hi[p]),
        .gate_lo (gate_lo[p]),
        .tripped (tripped[p])
      );
    end
  endgenerate

  // Brake path: same delay, no conflict check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brake_en <= 1'b0;
    else        brake_en <= !sync_cmd[NCMD-1];
  end

  assign fault_n = ~|tripped;

  AST_BRAKE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_cmd[NCMD-1] |=> brake_en); // R11
  AST_FAULT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> ((~gate_hi & ~gate_lo) != '0)); // R10
endmodule

// File: tb/leg_interlock_tb.sv
module leg_interlock_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_hi_n = 3'b111;
  logic [2:0] cmd_lo_n = 3'b111;
  logic       cmd_brake_n = 1'b1;
  logic [2:0] gate_hi, gate_lo;
  logic       brake_en, fault_n;
  int         n_run = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  leg_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
    .cmd_brake_n(cmd_brake_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .brake_en(brake_en), .fault_n(fault_n)
  );

  task automatic drive(input logic [2:0] hi, input logic [2:0] lo, input logic br);
    @(negedge clk);
    cmd_hi_n = hi; cmd_lo_n = lo; cmd_brake_n = br;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(input logic [2:0] hi, input logic [2:0] lo, input logic br);
    drive(hi, lo, br);
    settle();
  endtask

  task automatic check(input string tag, input logic [2:0] eh, input logic [2:0] el,
                       input logic eb, input logic ef);
    n_run++;
    if (gate_hi !== eh || gate_lo !== el || brake_en !== eb || fault_n !== ef) begin
      n_fail++;
      $display("FAIL %s: got hi=%b lo=%b br=%b f=%b, expected hi=%b lo=%b br=%b f=%b",
               tag, gate_hi, gate_lo, brake_en, fault_n, eh, el, eb, ef);
    end
  endtask

  task automatic t_reset();
    check("R1 reset state", 3'b000, 3'b000, 1'b0, 1'b1);
  endtask

  task automatic t_pass();
    drive(3'b110, 3'b011, 1'b1);
    repeat (2) @(posedge clk); @(negedge clk);
    check("R2 not yet after two edges", 3'b000, 3'b000, 1'b0, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R2 follow after three edges", 3'b001, 3'b100, 1'b0, 1'b1);
    step(3'b011, 3'b110, 1'b1);
    check("R2 second pattern", 3'b100, 3'b001, 1'b0, 1'b1);
    step(3'b111, 3'b111, 1'b1);
  endtask

  task automatic t_brake();
    step(3'b111, 3'b111, 1'b0);
    check("R11 brake follows", 3'b000, 3'b000, 1'b1, 1'b1);
    step(3'b110, 3'b110, 1'b0);
    check("R11 brake kept during trip", 3'b000, 3'b000, 1'b1, 1'b0);
    step(3'b111, 3'b111, 1'b1);
    step(3'b111, 3'b110, 1'b1);
    check("R11 cleanup release", 3'b000, 3'b001, 1'b0, 1'b1);
    step(3'b111, 3'b111, 1'b1);
  endtask

  task automatic t_trip_release();
    step(3'b101, 3'b111, 1'b1);
    check("R2 phase1 upper on", 3'b010, 3'b000, 1'b0, 1'b1);
    step(3'b101, 3'b101, 1'b1);
    check("R3 overlap trips phase1", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b100, 3'b101, 1'b1);
    check("R9 phase0 unaffected", 3'b001, 3'b000, 1'b0, 1'b0);
    step(3'b111, 3'b111, 1'b1);
    check("R4 latch holds when idle", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b101, 3'b111, 1'b1);
    check("R6 early edge no release", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b111, 3'b111, 1'b1);
    step(3'b111, 3'b101, 1'b1);
    check("R5 late edge releases", 3'b000, 3'b010, 1'b0, 1'b1);
    step(3'b111, 3'b111, 1'b1);
  endtask

  task automatic t_simul();
    step(3'b110, 3'b110, 1'b1);
    check("R3 simultaneous trip", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b111, 3'b111, 1'b1);
    step(3'b110, 3'b111, 1'b1);
    check("R7 upper edge no release", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b111, 3'b111, 1'b1);
    step(3'b111, 3'b110, 1'b1);
    check("R7 lower edge releases", 3'b000, 3'b001, 1'b0, 1'b1);
    step(3'b111, 3'b111, 1'b1);
  endtask

  task automatic t_retrip();
    step(3'b011, 3'b111, 1'b1);
    step(3'b011, 3'b011, 1'b1);
    check("R3 phase2 trips", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b011, 3'b111, 1'b1);
    check("R4 one command low holds", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b011, 3'b011, 1'b1);
    check("R8 late edge with partner low", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b111, 3'b111, 1'b1);
    check("R8 still latched", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b111, 3'b011, 1'b1);
    check("R5 phase2 released", 3'b000, 3'b100, 1'b0, 1'b1);
    step(3'b111, 3'b111, 1'b1);
  endtask

  task automatic t_two_phase();
    step(3'b010, 3'b010, 1'b1);
    check("R10 two phases trip", 3'b000, 3'b000, 1'b0, 1'b0);
    step(3'b111, 3'b111, 1'b1);
    step(3'b111, 3'b110, 1'b1);
    check("R10 fault kept while phase2 latched", 3'b000, 3'b001, 1'b0, 1'b0);
    step(3'b111, 3'b010, 1'b1);
    check("R10 fault clears after last", 3'b000, 3'b101, 1'b0, 1'b1);
    step(3'b111, 3'b111, 1'b1);
    check("R2 idle after all", 3'b000, 3'b000, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_pass();
    t_brake();
    t_trip_release();
    t_simul();
    t_retrip();
    t_two_phase();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule